// File: doc/BRIEF.md
# Serial Double-Buffered DAC Interface

This block is the digital front end of a 16-bit serial-input voltage DAC. A host drives a serial clock, a data line and an active-low frame select. While the frame select is low, each falling edge of the serial clock shifts one bit, most significant first, into a shift register. When the frame select rises after at least a full word, the last word shifted in is committed. It always goes to an input register. It goes on to the DAC register if the active-low load input is low. The load input can also move a held input-register word into the DAC register at any later time, so several chained devices can update together.

Bits pushed out of the top of the shift register appear on a serial output, so that devices can be cascaded. An active-low clear and an active-low power-down force the analog-facing code to mid-scale, which is zero volts in offset binary. Power-down takes priority over clear and also disables the serial output. A clear stays in effect after its input is released, until the next load. All control and serial inputs are treated as asynchronous and pass through a synchronizer into the system clock domain. All outputs are registered.

Top module: `dac_serial_if`

## Requirements
- R1: After reset, `dac_code` is 0x8000 (mid-scale, 0 V), `zero_force` is 1, `pwr_down` is 0 and `ser_dout` is 0.
- R2: With `pwr_n` and `clear_n` high and `load_n` low, a full frame loads both registers, `dac_code` shows the new word, and `zero_force` drops to 0.
- R3: A frame committed while `load_n` is high changes only the input register and leaves `dac_code` unchanged. A later low level on `load_n` moves the held word to `dac_code`.
- R4: A frame with fewer than 16 falling serial-clock edges is discarded, and `dac_code` keeps its value.
- R5: Bits are shifted in MSB first. Once 16 bits have been shifted, `ser_dout` shows the oldest bit still held. Each further edge moves the next older bit out. A frame longer than 16 edges commits the last 16 bits.
- R6: Serial-clock edges while `frame_n` is high shift nothing. Both the shift-register content seen on `ser_dout` and `dac_code` stay unchanged.
- R7: While `clear_n` is low, `dac_code` is 0x8000 and `zero_force` is 1, even when `load_n` is low. A frame written with `load_n` low during clear still reaches the DAC register. After `clear_n` rises, the output stays at 0x8000 until `load_n` is next low.
- R8: While `pwr_n` is low, `dac_code` is 0x8000, `pwr_down` is 1 and `ser_dout` is 0, whatever the clear and load inputs do. Frames are still accepted. When `pwr_n` rises, the stored DAC word is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data sampled on its falling edge |
| ser_din | input | 1 | Serial data in, MSB first |
| frame_n | input | 1 | Active-low frame select |
| load_n | input | 1 | Active-low DAC register load |
| clear_n | input | 1 | Active-low clear to mid-scale, latched until next load |
| pwr_n | input | 1 | Active-low power-down |
| ser_dout | output | 1 | Shift-register overflow output for chaining |
| dac_code | output | 16 | Effective offset-binary code for the converter |
| zero_force | output | 1 | Clear is in effect |
| pwr_down | output | 1 | Power-down is in effect |

## Verification
Any input change crosses two synchronizer flops before the logic sees it. A serial-clock fall therefore changes the shift register on the third clock edge and `ser_dout` on the fourth. A frame-select rise commits on the third edge, updates the registers on the fourth and reaches `dac_code` on the fifth. Clear, load and power-down levels reach the flags and `dac_code` within four edges. The bench holds every serial-clock phase for four system clocks. It waits at least eight clocks after a frame ends or a control level changes before it samples, so every check falls well after the due cycle and never on an active edge.

// File: rtl/dac_serial_pkg.sv
package dac_serial_pkg;

  // Control and serial inputs, bundled for the synchronizer
  typedef struct packed {
    logic sclk;
    logic sdin;
    logic frame_n;
    logic load_n;
    logic clear_n;
    logic pwr_n;
  } ctl_t;

  // Idle levels: clock low, selects and strobes inactive (high)
  localparam ctl_t CTL_IDLE = '{sclk: 1'b0, sdin: 1'b0, frame_n: 1'b1,
                                load_n: 1'b1, clear_n: 1'b1, pwr_n: 1'b1};

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int unsigned N      = 6,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [STAGES-1:0][N-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dac_shifter.sv
module dac_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_s,
  input  logic         sdin_s,
  input  logic         frame_n_s,
  output logic [W-1:0] word,
  output logic         commit,
  output logic         msb
);

  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic          sclk_d, frame_d;
  logic [CW-1:0] cnt;
  logic [W-1:0]  shreg;
  logic          shift_en, frame_end;

  assign shift_en  = sclk_d & ~sclk_s & ~frame_n_s;
  assign frame_end = ~frame_d & frame_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      frame_d <= 1'b1;
      cnt     <= '0;
      shreg   <= '0;
      commit  <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      frame_d <= frame_n_s;
      commit  <= frame_end && (cnt == FULL);
      if (frame_n_s) cnt <= '0;
      else if (shift_en && cnt != FULL) cnt <= cnt + 1'b1;
      if (shift_en) shreg <= {shreg[W-2:0], sdin_s};
    end
  end

  assign word = shreg;
  assign msb  = shreg[W-1];

  // R5
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> shreg[0] == $past(sdin_s));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    frame_n_s |=> $stable(shreg));

endmodule

// File: rtl/dac_regs.sv
module dac_regs #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         commit,
  input  logic [W-1:0] word,
  input  logic         load_n_s,
  input  logic         clear_n_s,
  input  logic         pwr_n_s,
  output logic [W-1:0] code_q,
  output logic         force_zero_q,
  output logic         pwr_down_q
);

  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] in_reg, dac_reg;
  logic         clr_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_reg       <= MID;
      dac_reg      <= MID;
      clr_lat      <= 1'b1;
      code_q       <= MID;
      force_zero_q <= 1'b1;
      pwr_down_q   <= 1'b0;
    end else begin
      if (commit) in_reg <= word;
      if (!load_n_s) dac_reg <= commit ? word : in_reg;
      if (!clear_n_s) clr_lat <= 1'b1;
      else if (!load_n_s) clr_lat <= 1'b0;
      code_q       <= (!pwr_n_s || !clear_n_s || clr_lat) ? MID : dac_reg;
      force_zero_q <= !clear_n_s || clr_lat;
      pwr_down_q   <= !pwr_n_s;
    end
  end

  // R3
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    load_n_s |=> $stable(dac_reg));
  // R4
  in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(in_reg));
  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !clear_n_s |=> (code_q == MID) && force_zero_q);
  // R8
  pd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_n_s |=> (code_q == MID) && pwr_down_q);

endmodule

// File: rtl/dac_serial_if.sv
module dac_serial_if #(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_din,
  input  logic             frame_n,
  input  logic             load_n,
  input  logic             clear_n,
  input  logic             pwr_n,
  output logic             ser_dout,
  output logic [WIDTH-1:0] dac_code,
  output logic             zero_force,
  output logic             pwr_down
);
  import dac_serial_pkg::*;

  ctl_t             raw, syn;
  logic [WIDTH-1:0] word;
  logic             commit, msb;

  assign raw = '{sclk: ser_clk, sdin: ser_din, frame_n: frame_n,
                 load_n: load_n, clear_n: clear_n, pwr_n: pwr_n};

  dac_sync #(.N($bits(ctl_t)), .STAGES(SYNC_STAGES), .RST(CTL_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  dac_shifter #(.W(WIDTH)) u_shift (
    .clk(clk), .rst(rst), .sclk_s(syn.sclk), .sdin_s(syn.sdin),
    .frame_n_s(syn.frame_n), .word(word), .commit(commit), .msb(msb)
  );

  dac_regs #(.W(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .commit(commit), .word(word),
    .load_n_s(syn.load_n), .clear_n_s(syn.clear_n), .pwr_n_s(syn.pwr_n),
    .code_q(dac_code), .force_zero_q(zero_force), .pwr_down_q(pwr_down)
  );

  always_ff @(posedge clk) begin
    if (rst) ser_dout <= 1'b0;
    else     ser_dout <= syn.pwr_n & msb;
  end

  // R8
  sdo_off_chk: assert property (@(posedge clk) disable iff (rst)
    !syn.pwr_n |=> !ser_dout);

endmodule

// File: tb/dac_serial_if_tb.sv
module dac_serial_if_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0, ser_din = 1'b0, frame_n = 1'b1;
  logic        load_n = 1'b1, clear_n = 1'b1, pwr_n = 1'b1;
  logic        ser_dout, zero_force, pwr_down;
  logic [15:0] dac_code;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dac_serial_if u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .frame_n(frame_n), .load_n(load_n), .clear_n(clear_n), .pwr_n(pwr_n),
    .ser_dout(ser_dout), .dac_code(dac_code), .zero_force(zero_force),
    .pwr_down(pwr_down)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] d, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = d[i];
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(4);
    end
  endtask

  task automatic frame(input logic [31:0] d, input int n);
    frame_n = 1'b0;
    wait_clk(4);
    send_bits(d, n);
    wait_clk(4);
    frame_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    wait_clk(6);
    load_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic t_reset();
    check("R1 code", dac_code, 32'h8000);
    check("R1 zero_force", zero_force, 1);
    check("R1 pwr_down", pwr_down, 0);
    check("R1 sdo", ser_dout, 0);
  endtask

  task automatic t_load_low();
    load_n = 1'b0;
    frame(32'h1234, 16);
    check("R2 code", dac_code, 32'h1234);
    check("R2 zero_force", zero_force, 0);
  endtask

  task automatic t_load_high();
    load_n = 1'b1;
    frame(32'hABCD, 16);
    check("R3 code held", dac_code, 32'h1234);
    pulse_load();
    check("R3 code after load", dac_code, 32'hABCD);
  endtask

  task automatic t_short();
    load_n = 1'b0;
    frame(32'h03FF, 10);
    check("R4 code", dac_code, 32'hABCD);
  endtask

  task automatic t_overflow();
    load_n = 1'b0;
    frame_n = 1'b0;
    wait_clk(4);
    send_bits(32'hA5F0, 16);
    wait_clk(4);
    check("R5 sdo after 16", ser_dout, 1);
    send_bits(32'h0, 1);
    wait_clk(4);
    check("R5 sdo after 17", ser_dout, 0);
    send_bits(32'h0F0F, 15);
    wait_clk(4);
    frame_n = 1'b1;
    wait_clk(10);
    check("R5 code last 16", dac_code, 32'h0F0F);
  endtask

  task automatic t_idle_clocks();
    send_bits(32'hFFFF, 16);
    wait_clk(6);
    check("R6 sdo", ser_dout, 0);
    check("R6 code", dac_code, 32'h0F0F);
  endtask

  task automatic t_clear();
    load_n = 1'b1;
    clear_n = 1'b0;
    wait_clk(8);
    check("R7 code", dac_code, 32'h8000);
    check("R7 zero_force", zero_force, 1);
    load_n = 1'b0;
    frame(32'h7777, 16);
    check("R7 code during clear", dac_code, 32'h8000);
    load_n = 1'b1;
    wait_clk(4);
    clear_n = 1'b1;
    wait_clk(10);
    check("R7 code after release", dac_code, 32'h8000);
    check("R7 zero_force after release", zero_force, 1);
    pulse_load();
    check("R7 code after load", dac_code, 32'h7777);
    check("R7 zero_force after load", zero_force, 0);
  endtask

  task automatic t_power_down();
    pwr_n = 1'b0;
    wait_clk(8);
    check("R8 code", dac_code, 32'h8000);
    check("R8 pwr_down", pwr_down, 1);
    load_n = 1'b0;
    frame(32'hF00D, 16);
    check("R8 sdo off", ser_dout, 0);
    check("R8 code during pd", dac_code, 32'h8000);
    clear_n = 1'b0;
    wait_clk(8);
    check("R8 pd over clear", pwr_down, 1);
    check("R8 zero_force with clear", zero_force, 1);
    clear_n = 1'b1;
    wait_clk(8);
    pwr_n = 1'b1;
    wait_clk(10);
    check("R8 code after pd", dac_code, 32'hF00D);
    check("R8 pwr_down after pd", pwr_down, 0);
    check("R8 sdo after pd", ser_dout, 1);
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    t_reset();
    t_load_low();
    t_load_high();
    t_short();
    t_overflow();
    t_idle_clocks();
    t_clear();
    t_power_down();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule